// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

The arbiter gathers interrupt conditions from a parameterised set of peripheral sources and one non-maskable input. Each source has an enable bit and a one-bit priority level. Two mask bits, `mask_i` and `mask_ui`, define three masking states. With `mask_i` clear, everything is open. With `mask_i` set and `mask_ui` clear, only level-1 sources and the non-maskable input get through. With both set, only the non-maskable input gets through.

Among the requests that pass the mask, the arbiter prefers level 1 over level 0. When two sources share a level, the lower source index wins. The non-maskable input beats every maskable source. A decision is taken only in a cycle where the CPU signals an instruction boundary. The acceptance then appears one cycle later as a single-cycle pulse, together with the winner's index and its vector address. At the same edge, both mask bits are forced to 1.

Requests that lose stay pending for as long as their conditions remain active. Saving the program counter and status, and fetching through the vector, are done by the CPU outside this block. A small select-based register port loads and reads back the enables, the levels and the mask bits.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the enables and levels read 0, both mask bits are 1, `acc_pulse` is 0 and `acc_vec` equals the base address.
- R2: A source takes part in arbitration only while its condition input is 1 and its enable bit is 1.
- R3: With `mask_i`=0, a level-1 request wins over any level-0 request.
- R4: Among eligible requests of equal level, the lowest source index wins.
- R5: With `mask_i`=0, a request of either level is accepted whatever `mask_ui` holds.
- R6: With `mask_i`=1 and `mask_ui`=0, only level-1 sources are accepted, and level-0 requests wait.
- R7: With both mask bits 1, no maskable source is accepted.
- R8: A rising edge on `nmi_in` is latched as pending. It wins over all maskable sources regardless of the masks, and the pending flag clears when it is accepted.
- R9: Acceptance happens only at a clock edge where `insn_done` is 1. `acc_pulse` is then high for the single following cycle.
- R10: On acceptance, both mask bits become 1. This overrides a mask write in the same cycle.
- R11: `acc_src` is 0 for the non-maskable input and k+1 for source k. `acc_vec` equals the base plus 4 times `acc_src`.
- R12: A request that loses arbitration is not dropped. It is accepted at a later boundary once it becomes the winner.
- R13: The register port writes on `reg_we` at the clock edge, with select 0 = enables, 1 = levels, 2 = mask (bit 0 `mask_i`, bit 1 `mask_ui`). `reg_rdata` shows the selected register combinationally, and reads 0 for select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_cond | input | NSRC | Peripheral interrupt conditions, level sensitive |
| nmi_in | input | 1 | Non-maskable request, rising edge latched |
| insn_done | input | 1 | Instruction-boundary strobe |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Selected register contents |
| mask_i | output | 1 | Primary mask bit |
| mask_ui | output | 1 | Secondary mask bit |
| acc_pulse | output | 1 | One-cycle acceptance pulse |
| acc_src | output | $clog2(NSRC+1) | Accepted source index |
| acc_vec | output | VEC_W | Vector address of the accepted source |

## Verification
Every registered result is due exactly one edge after the inputs that cause it: the acceptance pulse, the index, the vector, the mask bits, the register contents and the non-maskable pending flag. `reg_rdata` is the one exception and follows `reg_sel` in the same cycle. The bench drives inputs just after the falling edge. It advances a behavioural model using those inputs, then compares every output at the next falling edge, one register stage later. Directed boundary checks also confirm the expected winner in that same sampling slot.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 8,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0100,
  localparam int IDX_W = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_cond,
  input  logic             nmi_in,
  input  logic             insn_done,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [NSRC-1:0]  reg_wdata,
  output logic [NSRC-1:0]  reg_rdata,
  output logic             mask_i,
  output logic             mask_ui,
  output logic             acc_pulse,
  output logic [IDX_W-1:0] acc_src,
  output logic [VEC_W-1:0] acc_vec
);

  logic [NSRC-1:0] en_r, lvl_r, elig;
  logic nmi_d, nmi_pend, found, take;
  logic [IDX_W-1:0] pick, win;

  wire [NSRC-1:0] req = src_cond & en_r;
  wire [NSRC-1:0] hi  = req & lvl_r;
  wire nmi_rise = nmi_in & ~nmi_d;

  always_comb begin
    if (!mask_i)       elig = (|hi) ? hi : req;
    else if (!mask_ui) elig = hi;
    else               elig = '0;
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i + 1);
      end
    end
  end

  assign take = insn_done & (nmi_pend | found);
  assign win  = nmi_pend ? '0 : pick;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = en_r;
      2'd1:    reg_rdata = lvl_r;
      2'd2:    reg_rdata = {{(NSRC-2){1'b0}}, mask_ui, mask_i};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r      <= '0;
      lvl_r     <= '0;
      mask_i    <= 1'b1;
      mask_ui   <= 1'b1;
      nmi_d     <= 1'b0;
      nmi_pend  <= 1'b0;
      acc_pulse <= 1'b0;
      acc_src   <= '0;
      acc_vec   <= VEC_BASE;
    end else begin
      nmi_d <= nmi_in;
      if (nmi_rise)              nmi_pend <= 1'b1;
      else if (take && nmi_pend) nmi_pend <= 1'b0;
      if (reg_we && reg_sel == 2'd0) en_r  <= reg_wdata;
      if (reg_we && reg_sel == 2'd1) lvl_r <= reg_wdata;
      if (take) begin
        mask_i  <= 1'b1;
        mask_ui <= 1'b1;
      end else if (reg_we && reg_sel == 2'd2) begin
        mask_i  <= reg_wdata[0];
        mask_ui <= reg_wdata[1];
      end
      acc_pulse <= take;
      if (take) begin
        acc_src <= win;
        acc_vec <= VEC_BASE + (VEC_W'(win) << 2);
      end
    end
  end

  wire [NSRC:0] req_ext = {req, 1'b0};
  wire [NSRC:0] hi_ext  = {hi, 1'b0};
  wire [NSRC:0] src_sel = {{NSRC{1'b0}}, 1'b1} << acc_src;

  AST_PULSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> $past(insn_done)); // R9
  AST_MASKS_SET_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> (mask_i && mask_ui)); // R10
  AST_FULL_MASK_NMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && $past(mask_i && mask_ui)) |-> (acc_src == '0)); // R7
  AST_PARTIAL_MASK_LEVEL1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && acc_src != '0 && $past(mask_i)) |-> (|($past(hi_ext) & src_sel))); // R6
  AST_WINNER_WAS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && acc_src != '0) |-> (|($past(req_ext) & src_sel))); // R2

endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int N = 8;
  localparam int IW = $clog2(N + 1);
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_cond = '0, reg_wdata = '0;
  logic nmi_in = 1'b0, insn_done = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [N-1:0] reg_rdata;
  logic mask_i, mask_ui, acc_pulse;
  logic [IW-1:0] acc_src;
  logic [15:0] acc_vec;

  irq_arbiter #(.NSRC(N), .VEC_W(16), .VEC_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .nmi_in(nmi_in),
    .insn_done(insn_done), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mask_i(mask_i),
    .mask_ui(mask_ui), .acc_pulse(acc_pulse), .acc_src(acc_src), .acc_vec(acc_vec));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur = "R1";

  logic [N-1:0] m_en = '0, m_lvl = '0;
  bit m_i = 1, m_ui = 1, m_nd = 0, m_pend = 0, e_pulse = 0;
  int e_src = 0;
  int e_vec = BASE;

  task automatic check(string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", cur, what, got, exp);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] rq, hi, cand;
    int pick = -1;
    bit take;
    int nidx;
    rq = src_cond & m_en;
    hi = rq & m_lvl;
    if (!m_i) cand = (hi != 0) ? hi : rq;
    else if (!m_ui) cand = hi;
    else cand = '0;
    for (int i = 0; i < N; i++) if (cand[i] && pick < 0) pick = i;
    take = insn_done && (m_pend || pick >= 0);
    nidx = m_pend ? 0 : pick + 1;
    if (nmi_in && !m_nd) m_pend = 1;
    else if (take && m_pend) m_pend = 0;
    m_nd = nmi_in;
    if (reg_we && reg_sel == 0) m_en = reg_wdata;
    if (reg_we && reg_sel == 1) m_lvl = reg_wdata;
    if (take) begin m_i = 1; m_ui = 1; end
    else if (reg_we && reg_sel == 2) begin m_i = reg_wdata[0]; m_ui = reg_wdata[1]; end
    e_pulse = take;
    if (take) begin e_src = nidx; e_vec = BASE + 4 * nidx; end
  endtask

  task automatic tick();
    int rd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    case (reg_sel)
      2'd0: rd = int'(m_en);
      2'd1: rd = int'(m_lvl);
      2'd2: rd = {m_ui, m_i};
      default: rd = 0;
    endcase
    check("acc_pulse", int'(acc_pulse), int'(e_pulse));
    check("acc_src", int'(acc_src), e_src);
    check("acc_vec", int'(acc_vec), e_vec);
    check("mask_i", int'(mask_i), int'(m_i));
    check("mask_ui", int'(mask_ui), int'(m_ui));
    check("reg_rdata", int'(reg_rdata), rd);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(logic [1:0] sel, logic [N-1:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic boundary(int exp);
    insn_done = 1;
    tick();
    insn_done = 0;
    check("boundary pulse", int'(acc_pulse), int'(exp >= 0));
    if (exp >= 0) begin
      check("boundary src", int'(acc_src), exp);
      check("boundary vec", int'(acc_vec), BASE + 4 * exp);
      check("boundary masks", int'({mask_ui, mask_i}), 3);
    end
  endtask

  initial begin
    #5_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1";
    check("reset pulse", int'(acc_pulse), 0);
    check("reset vec", int'(acc_vec), BASE);
    check("reset masks", int'({mask_ui, mask_i}), 3);
    idle(2);

    cur = "R13";
    wr(0, 8'b0110_0110);
    wr(1, 8'b0110_0000);
    reg_sel = 1; tick();
    check("levels readback", int'(reg_rdata), 8'h60);
    reg_sel = 3; tick();
    check("select3 readback", int'(reg_rdata), 0);

    cur = "R2";
    wr(2, 0);
    src_cond = 8'b1000_0001;
    boundary(-1);

    cur = "R5";
    wr(2, 2'b10);
    src_cond = 8'b0000_0010;
    boundary(2);

    cur = "R3";
    wr(2, 0);
    src_cond = 8'b0010_0010;
    boundary(6);

    cur = "R4";
    wr(2, 0);
    src_cond = 8'b0110_0000;
    boundary(6);
    wr(2, 0);
    src_cond = 8'b0000_0110;
    boundary(2);

    cur = "R6";
    wr(2, 2'b01);
    src_cond = 8'b0000_0100;
    boundary(-1);
    src_cond = 8'b0100_0100;
    boundary(7);

    cur = "R7";
    wr(2, 2'b11);
    src_cond = 8'hFF;
    boundary(-1);

    cur = "R8";
    nmi_in = 1; tick();
    boundary(0);
    boundary(-1);
    nmi_in = 0; tick();

    cur = "R9";
    src_cond = 8'b0000_0100;
    wr(2, 0);
    idle(5);
    boundary(3);

    cur = "R10";
    wr(2, 0);
    reg_we = 1; reg_sel = 2; reg_wdata = 0; insn_done = 1;
    tick();
    reg_we = 0; insn_done = 0;
    check("override masks", int'({mask_ui, mask_i}), 3);

    cur = "R11";
    wr(2, 0);
    src_cond = 8'b0100_0000;
    boundary(7);

    cur = "R12";
    src_cond = 8'b0000_0110;
    wr(2, 0);
    boundary(2);
    wr(2, 0);
    src_cond = 8'b0000_0100;
    boundary(3);

    cur = "R12 random";
    for (int k = 0; k < 3000; k++) begin
      src_cond  = N'($urandom);
      nmi_in    = ($urandom % 16) == 0;
      insn_done = ($urandom % 3) == 0;
      reg_we    = ($urandom % 4) == 0;
      reg_sel   = 2'($urandom);
      reg_wdata = N'($urandom);
      tick();
    end
    reg_we = 0; insn_done = 0;
    idle(2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule